// File: doc/BRIEF.md
# Convolution Supply-Droop Estimator with Two-Sided Clamp

Each clock this block takes an unsigned estimate of the current the core draws. It convolves the recent history of that estimate with a programmable kernel of signed coefficients. The kernel models how the power network responds to a single one-clock current pulse, so the convolution gives a running estimate of how far the supply has moved. A programmable signed offset minus the convolution sum gives the voltage deviation estimate. Drawing more current therefore lowers the estimate.

The deviation is compared against an upper and a lower limit on every clock. Above the upper limit, the block raises `forceOn`, which turns on units that would otherwise be clock gated and so pushes current up. Below the lower limit, it raises `stall`, which gates clocks or fetch and so pushes current down. Between the two limits neither output is raised. Each side of the clamp has its own enable. The outputs feed back into the current estimate, which closes the loop, and the loop latency stays at two clocks.

All settings go through a simple write port: the kernel coefficients, the offset, both limits and the two enables.

Top module: `droop_clamp`

## Requirements
- R1: While reset is low, and after it is released, `forceOn` and `stall` are 0 and `voltDev` is 0. Reset clears the sample history, all coefficients, the offset, both limits and both enables.
- R2: A current sample presented at clock edge m is reflected in `voltDev` after edge m+1. The value is `voltDev = offset - sum(coef[k] * cur(m-k))` for k = 0..TAPS-1, where `cur` is unsigned and `coef` is an 8-bit two's-complement value.
- R3: The kernel is truncated after the last tap: a sample older than TAPS-1 clocks contributes nothing.
- R4: Coefficients may be negative, and a negative coefficient raises the deviation for a nonzero current.
- R5: When offset minus the sum falls outside the signed ACC_W range, `voltDev` saturates to the most positive or most negative ACC_W value instead of wrapping.
- R6: `forceOn` is 1 exactly when the upper clamp is enabled, the limits are ordered, and `voltDev` is strictly greater than the upper limit.
- R7: `stall` is 1 exactly when the lower clamp is enabled, the limits are ordered, and `voltDev` is strictly less than the lower limit.
- R8: A deviation equal to a limit, or lying between the limits, raises neither output. The two outputs are never 1 at the same time.
- R9: The enable word is written at address TAPS+3, with bit 0 enabling the upper clamp and bit 1 enabling the lower clamp. The block supports upper-only, lower-only, both and neither. A disabled side never raises its output.
- R10: If the lower limit is programmed greater than the upper limit, both outputs stay 0 whatever the deviation.
- R11: The write map is as follows. Addresses 0..TAPS-1 hold the coefficients, taken from data bits [7:0]. Address TAPS holds the offset, TAPS+1 the upper limit and TAPS+2 the lower limit, each a full ACC_W-bit signed value. A setting written at edge m takes effect for the outputs after edge m+1. Writes to any address above TAPS+3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| currentIn | input | CUR_W | Per-clock unsigned current estimate |
| cfgWrEn | input | 1 | Setting write strobe |
| cfgAddr | input | ADDR_W | Setting address |
| cfgWrData | input | ACC_W | Setting write data |
| voltDev | output | ACC_W | Signed supply deviation estimate |
| forceOn | output | 1 | Request to force idle units on (estimate too high) |
| stall | output | 1 | Request to gate clocks or fetch (estimate too low) |

## Verification
The hardest cases to reach are saturation and exact equality with a limit. Saturation needs the whole kernel window filled with full-scale current against an extreme offset. The bench holds a current of 255 for longer than the kernel with every coefficient at one extreme, and it does this in both signs. To hit each limit exactly, the bench drains the history with zero current so that the deviation equals the offset. It then steps the offset across each limit one unit at a time. Coefficients are changed only after such a drain. This keeps the reference convolution exact while settings move.

// File: rtl/droop_clamp_pkg.sv
package droop_clamp_pkg;
  // coefficient width and the index width carried by the write strobe
  localparam int COEF_W = 8;
  localparam int IDX_W  = 8;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic                     coefWe;
    logic [IDX_W-1:0]         coefIdx;
    logic signed [COEF_W-1:0] coefVal;
  } coefStrobe_t;
endpackage

// File: rtl/droop_clamp_fir.sv
module droop_clamp_fir
  import droop_clamp_pkg::*;
#(
  parameter int TAPS  = 25,
  parameter int CUR_W = 8,
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [CUR_W-1:0]        currentIn,
  input  coefStrobe_t             strb,
  output logic signed [ACC_W-1:0] convSum
);
  localparam int PROD_W = CUR_W + 1 + COEF_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic signed [CUR_W:0] curS;
  assign curS = $signed({1'b0, currentIn});

  // transposed form: each stage adds its own product to the stage behind it
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic signed [COEF_W-1:0] coefR;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prodExt;
    logic signed [ACC_W-1:0]  partR;

    assign prod    = coefR * curS;
    assign prodExt = {{EXT_W{prod[PROD_W-1]}}, prod};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        coefR <= '0;
      end else if (strb.coefWe && (strb.coefIdx == IDX_W'(k))) begin
        coefR <= strb.coefVal;
      end
    end

    if (k == TAPS - 1) begin : g_last
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) partR <= '0;
        else       partR <= prodExt;
      end
    end else begin : g_mid
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) partR <= '0;
        else       partR <= g_tap[k+1].partR + prodExt;
      end
    end
  end

  assign convSum = g_tap[0].partR;
endmodule

// File: rtl/droop_clamp_ctrl.sv
module droop_clamp_ctrl
  import droop_clamp_pkg::*;
#(
  parameter int TAPS   = 25,
  parameter int ACC_W  = 24,
  parameter int ADDR_W = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWrEn,
  input  logic [ADDR_W-1:0]       cfgAddr,
  input  logic [ACC_W-1:0]        cfgWrData,
  input  logic signed [ACC_W-1:0] convSum,
  output coefStrobe_t             strb,
  output logic signed [ACC_W-1:0] voltDev,
  output logic                    forceOn,
  output logic                    stall
);
  localparam logic [ADDR_W-1:0] OFS_A  = ADDR_W'(TAPS);
  localparam logic [ADDR_W-1:0] UP_A   = ADDR_W'(TAPS + 1);
  localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(TAPS + 2);
  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(TAPS + 3);
  localparam logic signed [ACC_W-1:0] DEV_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] DEV_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] offsetR, upThr, lowThr;
  logic                    modeUp, modeLow;

  // coefficient writes go straight to the datapath
  always_comb begin
    strb.coefWe  = cfgWrEn && (cfgAddr < OFS_A);
    strb.coefIdx = IDX_W'(cfgAddr);
    strb.coefVal = cfgWrData[COEF_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offsetR <= '0;
      upThr   <= '0;
      lowThr  <= '0;
      modeUp  <= 1'b0;
      modeLow <= 1'b0;
    end else if (cfgWrEn) begin
      unique case (cfgAddr)
        OFS_A:   offsetR <= cfgWrData;
        UP_A:    upThr   <= cfgWrData;
        LO_A:    lowThr  <= cfgWrData;
        MODE_A:  begin
          modeUp  <= cfgWrData[0];
          modeLow <= cfgWrData[1];
        end
        default: ;
      endcase
    end
  end

  // offset minus convolution, one guard bit, then saturate
  logic signed [ACC_W:0]   diffW;
  logic signed [ACC_W-1:0] devSat;
  logic                    ordered;

  always_comb begin
    diffW = {offsetR[ACC_W-1], offsetR} - {convSum[ACC_W-1], convSum};
    if (diffW[ACC_W] != diffW[ACC_W-1]) devSat = diffW[ACC_W] ? DEV_MIN : DEV_MAX;
    else                                devSat = diffW[ACC_W-1:0];
    ordered = !(lowThr > upThr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      voltDev <= '0;
      forceOn <= 1'b0;
      stall   <= 1'b0;
    end else begin
      voltDev <= devSat;
      forceOn <= modeUp  && ordered && (devSat > upThr);
      stall   <= modeLow && ordered && (devSat < lowThr);
    end
  end
endmodule

// File: rtl/droop_clamp.sv
module droop_clamp
  import droop_clamp_pkg::*;
#(
  parameter int  TAPS   = 25,
  parameter int  CUR_W  = 8,
  parameter int  ACC_W  = 24,
  localparam int ADDR_W = $clog2(TAPS + 4)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [CUR_W-1:0]        currentIn,
  input  logic                    cfgWrEn,
  input  logic [ADDR_W-1:0]       cfgAddr,
  input  logic [ACC_W-1:0]        cfgWrData,
  output logic signed [ACC_W-1:0] voltDev,
  output logic                    forceOn,
  output logic                    stall
);
  coefStrobe_t             strb;
  logic signed [ACC_W-1:0] convSum;

  droop_clamp_fir #(.TAPS(TAPS), .CUR_W(CUR_W), .ACC_W(ACC_W)) u_fir (
    .clk(clk), .rstN(rstN), .currentIn(currentIn), .strb(strb), .convSum(convSum)
  );

  droop_clamp_ctrl #(.TAPS(TAPS), .ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .convSum(convSum), .strb(strb),
    .voltDev(voltDev), .forceOn(forceOn), .stall(stall)
  );
endmodule

// File: rtl/droop_clamp_chk.sv
module droop_clamp_chk #(
  parameter int ACC_W = 24
) (
  input logic                    clk,
  input logic                    rstN,
  input logic signed [ACC_W-1:0] voltDev,
  input logic                    forceOn,
  input logic                    stall,
  input logic signed [ACC_W-1:0] upThr,
  input logic signed [ACC_W-1:0] lowThr,
  input logic                    modeUp,
  input logic                    modeLow
);
  // R1: leaving reset with both requests low and a zero estimate
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (!forceOn && !stall && voltDev == '0));

  // R6 and R9: force only above the upper limit with the upper side enabled
  p_force_above_r6: assert property (@(posedge clk) disable iff (!rstN)
    forceOn |-> (($past(modeUp) == 1'b1) && (voltDev > $past(upThr))));

  // R7 and R9: stall only below the lower limit with the lower side enabled
  p_stall_below_r7: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (($past(modeLow) == 1'b1) && (voltDev < $past(lowThr))));

  // R8: never both requests at once
  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(forceOn && stall));

  // R8: inside the band, including its edges, nothing is requested
  p_dead_band_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((voltDev <= $past(upThr)) && (voltDev >= $past(lowThr))) |-> (!forceOn && !stall));

  // R10: inverted limits silence both requests
  p_inverted_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lowThr) > $past(upThr)) |-> (!forceOn && !stall));
endmodule

bind droop_clamp droop_clamp_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rstN(rstN), .voltDev(voltDev), .forceOn(forceOn), .stall(stall),
  .upThr(u_ctrl.upThr), .lowThr(u_ctrl.lowThr),
  .modeUp(u_ctrl.modeUp), .modeLow(u_ctrl.modeLow)
);

// File: tb/sim_droop_clamp.sv
module sim_droop_clamp;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS   = 25;
  localparam int CUR_W  = 8;
  localparam int ACC_W  = 24;
  localparam int ADDR_W = $clog2(TAPS + 4);
  localparam longint DMAX = (64'sd1 <<< (ACC_W - 1)) - 1;
  localparam longint DMIN = -(64'sd1 <<< (ACC_W - 1));

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CUR_W-1:0] currentIn = '0;
  logic cfgWrEn = 1'b0;
  logic [ADDR_W-1:0] cfgAddr = '0;
  logic [ACC_W-1:0] cfgWrData = '0;
  logic signed [ACC_W-1:0] voltDev;
  logic forceOn, stall;

  droop_clamp #(.TAPS(TAPS), .CUR_W(CUR_W), .ACC_W(ACC_W)) u0 (
    .clk(clk), .rstN(rstN), .currentIn(currentIn), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .voltDev(voltDev),
    .forceOn(forceOn), .stall(stall)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int     due;
    longint dev;
    bit     fo;
    bit     st;
    string  tag;
  } item_t;

  item_t q[$];
  int nChecks = 0;
  int nFails  = 0;
  int edgeCnt = 0;
  bit done    = 1'b0;

  // reference state
  longint histM[TAPS];
  longint coefM[TAPS];
  longint offM, upM, loM;
  bit     upEnM, loEnM;

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  task automatic modelClear();
    for (int k = 0; k < TAPS; k++) begin
      histM[k] = 0;
      coefM[k] = 0;
    end
    offM = 0; upM = 0; loM = 0; upEnM = 0; loEnM = 0;
  endtask

  task automatic check(input bit ok, input string msg);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s", msg);
    end
  endtask

  // driver: one clock of stimulus, then the expected result goes to the queue
  task automatic step(input int cur, input bit we, input int addr,
                      input logic [ACC_W-1:0] data, input string tag);
    item_t it;
    longint conv, dev;
    @(negedge clk);
    currentIn = CUR_W'(cur);
    cfgWrEn   = we;
    cfgAddr   = ADDR_W'(addr);
    cfgWrData = data;
    @(posedge clk);
    #1;
    for (int k = TAPS - 1; k > 0; k--) histM[k] = histM[k-1];
    histM[0] = cur;
    conv = 0;
    for (int k = 0; k < TAPS; k++) conv += coefM[k] * histM[k];
    if (we) begin
      if (addr < TAPS)           coefM[addr] = longint'($signed(data[7:0]));
      else if (addr == TAPS)     offM = longint'($signed(data));
      else if (addr == TAPS + 1) upM  = longint'($signed(data));
      else if (addr == TAPS + 2) loM  = longint'($signed(data));
      else if (addr == TAPS + 3) begin upEnM = data[0]; loEnM = data[1]; end
    end
    dev = offM - conv;
    if (dev > DMAX) dev = DMAX;
    if (dev < DMIN) dev = DMIN;
    it.due = edgeCnt + 1;
    it.dev = dev;
    it.fo  = upEnM && !(loM > upM) && (dev > upM);
    it.st  = loEnM && !(loM > upM) && (dev < loM);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input int addr, input logic [ACC_W-1:0] data, input string tag);
    step(0, 1'b1, addr, data, tag);
  endtask

  task automatic run(input int cur, input int n, input string tag);
    for (int i = 0; i < n; i++) step(cur, 1'b0, 0, '0, tag);
  endtask

  task automatic runRand(input int n, input string tag);
    for (int i = 0; i < n; i++) step(int'($urandom_range(255)), 1'b0, 0, '0, tag);
  endtask

  task automatic doReset(input string tag);
    while (q.size() != 0) @(negedge clk);
    #1;
    rstN = 1'b0;
    cfgWrEn = 1'b0;
    currentIn = '0;
    #1;
    check(forceOn == 1'b0 && stall == 1'b0 && voltDev == '0,
          $sformatf("%s reset state dev=%0d/0 force=%b/0 stall=%b/0", tag, voltDev, forceOn, stall));
    repeat (2) @(posedge clk);
    modelClear();
    @(negedge clk);
    #1;
    rstN = 1'b1;
  endtask

  // monitor: pop and compare each result when it is due
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() != 0 && q[0].due <= edgeCnt) begin
        item_t it;
        it = q.pop_front();
        check(it.due == edgeCnt && longint'(voltDev) == it.dev && forceOn == it.fo && stall == it.st,
              $sformatf("%s dev=%0d/%0d force=%b/%b stall=%b/%b", it.tag,
                        voltDev, it.dev, forceOn, it.fo, stall, it.st));
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired, no requirement reached: got timeout, expected end");
    finishRun();
  end

  initial begin
    modelClear();
    #2;
    check(forceOn == 1'b0 && stall == 1'b0 && voltDev == '0,
          $sformatf("R1 initial reset dev=%0d/0 force=%b/0 stall=%b/0", voltDev, forceOn, stall));
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    rstN = 1'b1;

    // R11: settings map, R9: both sides on
    wr(TAPS, 0, "R11 offset");
    wr(TAPS + 1, 100, "R11 upper");
    wr(TAPS + 2, -100, "R11 lower");
    wr(TAPS + 3, 3, "R9 both");
    for (int k = 0; k < TAPS; k++) wr(k, ((k * 37) % 29) - 14, "R11 coef");

    // R2, R3, R4: unit pulse walks out the kernel then disappears
    step(1, 1'b0, 0, '0, "R2 impulse");
    run(0, TAPS + 4, "R3 R4 impulse tail");
    step(200, 1'b0, 0, '0, "R6 R7 big pulse");
    run(0, TAPS + 2, "R3 R6 R7 pulse tail");
    runRand(60, "R2 R6 R7 mixed");
    run(0, TAPS + 1, "R3 drain");

    // R9: each side alone and none
    wr(TAPS + 3, 1, "R9 upper only");
    runRand(40, "R9 upper only");
    wr(TAPS + 3, 2, "R9 lower only");
    runRand(40, "R9 lower only");
    wr(TAPS + 3, 0, "R9 none");
    runRand(30, "R9 none");
    run(0, TAPS + 1, "R9 drain");

    // R8, R6, R7: step the offset across each limit
    wr(TAPS + 3, 3, "R8 mode");
    wr(TAPS + 1, 50, "R8 upper");
    wr(TAPS + 2, -50, "R8 lower");
    wr(TAPS, 50, "R8 at upper");     run(0, 2, "R8 equal upper");
    wr(TAPS, 51, "R6 above");        run(0, 2, "R6 one above");
    wr(TAPS, -50, "R8 at lower");    run(0, 2, "R8 equal lower");
    wr(TAPS, -51, "R7 below");       run(0, 2, "R7 one below");
    wr(TAPS, 0, "R8 middle");        run(0, 2, "R8 middle");

    // R10: inverted limits
    wr(TAPS + 1, -10, "R10 upper");
    wr(TAPS + 2, 10, "R10 lower");
    wr(TAPS, 100, "R10 high");       run(0, 2, "R10 high");
    wr(TAPS, -100, "R10 low");       run(0, 2, "R10 low");
    runRand(20, "R10 mixed");
    run(0, TAPS + 1, "R10 drain");

    // R11: writes above the map change nothing
    wr(TAPS + 1, 20, "R11 upper");
    wr(TAPS + 2, -20, "R11 lower");
    wr(TAPS, 0, "R11 offset");
    for (int a = TAPS + 4; a < (1 << ADDR_W); a++) wr(a, 24'h800001, "R11 unused addr");
    run(0, 2, "R11 unused addr no effect");

    // R5: saturate low then high
    for (int k = 0; k < TAPS; k++) wr(k, 127, "R5 coef max");
    wr(TAPS, -8000000, "R5 offset low");
    run(255, TAPS + 5, "R5 saturate low");
    run(0, TAPS + 1, "R5 drain");
    for (int k = 0; k < TAPS; k++) wr(k, -128, "R5 coef min");
    wr(TAPS, 8000000, "R5 offset high");
    run(255, TAPS + 5, "R5 saturate high");

    // R1: reset in mid run clears history and settings
    doReset("R1 mid run");
    step(255, 1'b0, 0, '0, "R1 cleared kernel");
    run(0, 4, "R1 cleared kernel");

    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    finishRun();
  end
endmodule